// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of an on-chip flash controller. A simple write-only register bus carries four kinds of write: a timing divisor, an opcode, a status/launch word, and array writes whose address and data are captured for the next operation. The block turns the bus clock into a slow timing tick. It checks that the steps of each command arrive in the required order. It rejects bad sequences and writes to protected regions. It then holds the operation active for a fixed number of timing ticks before it reports completion.

The storage array is not part of this block. A stub interface carries the captured address and data, plus indications of whether a program, erase or mass erase is in progress. Software writes the divisor once after reset. After that, each command is a sequence of three writes: an array write, then an opcode write, then a launch. The next command may start only once the previous one has completed and both error flags are clear.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, busy, div_set, acc_err, prot_err and every array stub output are 0, and cmd_done is 1.
- R2: The divisor (register select 0, value in wr_data[5:0]) is accepted only when div_set is 0 and both error flags are clear. Any later divisor write has no effect, so operation durations stay unchanged.
- R3: Once div_set is 1, tick pulses for one cycle every divisor+1 bus cycles. A launch restarts the tick phase.
- R4: An array write (register select 3) made before the divisor is set raises acc_err.
- R5: An opcode write (register select 1) raises acc_err and discards the sequence in either of two cases: no array write has been captured since the last command, or the code is not one of 0x05 blank check, 0x20 byte program, 0x25 burst program, 0x40 sector erase, 0x41 mass erase or 0x47 erase abort.
- R6: A launch (register select 2, wr_data bit 7 = 1) without a preceding accepted opcode raises acc_err and starts nothing.
- R7: Writing register select 2 with bit 4 = 1 clears acc_err, and with bit 5 = 1 clears prot_err. While either flag is set, divisor writes, array writes, opcode writes and launches are ignored.
- R8: An accepted launch holds busy high, with cmd_done low, for exactly N*(divisor+1) bus cycles. N is 4 for blank check, 9 for byte program, 4 for burst program, 4000 for sector erase, 20000 for mass erase and 4 for erase abort. When busy drops, cmd_done rises.
- R9: With prot_on = 1, sectors whose index (address bits [11:9]) is at or above prot_from are protected. A launch of mass erase, or of a program or sector erase aimed at a protected sector, raises prot_err and does not start.
- R10: While an operation runs, arr_addr carries the captured address. arr_prog is high for program opcodes, and arr_erase is high for sector and mass erase, with arr_mass high only for mass erase. arr_data carries the captured data for program opcodes and 0 for all others.
- R11: An array, opcode or launch write made while busy raises acc_err and leaves the running operation and its duration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 divisor, 1 opcode, 2 status/launch, 3 array |
| wr_addr | input | 12 | Array address for array writes |
| wr_data | input | 8 | Write data |
| prot_on | input | 1 | Protection enable |
| prot_from | input | 3 | Lowest protected sector index |
| div_set | output | 1 | Divisor has been written |
| tick | output | 1 | Timing tick pulse |
| busy | output | 1 | Operation in progress |
| cmd_done | output | 1 | No operation in progress |
| acc_err | output | 1 | Access error flag |
| prot_err | output | 1 | Protection violation flag |
| arr_prog | output | 1 | Program active toward the array |
| arr_erase | output | 1 | Erase active toward the array |
| arr_mass | output | 1 | Whole-array erase active |
| arr_addr | output | 12 | Captured address |
| arr_data | output | 8 | Captured data for programming |

## Verification
The hardest case to reach is a bus write that lands while an operation runs. It has to set the error flag without cutting the timed window short. The bench launches a byte program and then issues an opcode write in the middle of it. A scoreboard still expects the full duration when busy falls. A second hard case is a rewrite of the divisor. It can only be observed through later timing, so the bench rewrites the divisor after a second reset and compares the measured busy length against the value the first write implies.

// File: rtl/flash_seq_pkg.sv
// Shared definitions for the flash command sequencer: register selects,
// sequence states, opcodes and status bit positions.
package flash_seq_pkg;

    typedef enum logic [1:0] {
        SEL_DIV  = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_ARR  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LATCHED,
        SQ_ARMED,
        SQ_RUN
    } seq_state_e;

    localparam logic [7:0] OP_BLANK = 8'h05;
    localparam logic [7:0] OP_BYTE  = 8'h20;
    localparam logic [7:0] OP_BURST = 8'h25;
    localparam logic [7:0] OP_SECT  = 8'h40;
    localparam logic [7:0] OP_MASS  = 8'h41;
    localparam logic [7:0] OP_ABORT = 8'h47;

    localparam int ST_LAUNCH = 7;
    localparam int ST_PERR   = 5;
    localparam int ST_AERR   = 4;

    // True for the six opcodes the sequencer runs.
    function automatic logic op_valid(input logic [7:0] code);
        return (code == OP_BLANK) || (code == OP_BYTE) || (code == OP_BURST) ||
               (code == OP_SECT)  || (code == OP_MASS) || (code == OP_ABORT);
    endfunction

endpackage

// File: rtl/flash_tick_gen.sv
// Timing tick generator. Produces a one-cycle pulse every div+1 bus cycles
// once enabled. Assumes div only changes while en is low; restart
// re-aligns the phase so the first tick follows div+1 cycles later.
module flash_tick_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Pulse when the phase counter reaches the divisor.
    assign tick = en && (cnt == div);

    // Phase counter: wraps at div, cleared on restart or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !en) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick); // R3

endmodule

// File: rtl/flash_op_timer.sv
// Operation timer. Loaded with a tick count at launch, counts down one per
// tick, and flags the tick that ends the operation. Assumes load never
// coincides with a running count.
module flash_op_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             running,
    output logic             fin
);
    logic [CNT_W-1:0] rem;

    assign running = (rem != '0);
    assign fin     = tick && (rem == CNT_W'(1));

    // Remaining-ticks counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (load) begin
            rem <= load_val;
        end else if (tick && running) begin
            rem <= rem - 1'b1;
        end
    end

    AST_STOP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(tick)); // R8

endmodule

// File: rtl/flash_cmd_seq.sv
// Flash command sequencer top. Decodes register writes, enforces the order
// array-write -> opcode -> launch, guards the write-once divisor, checks
// protection, and times each operation in timing ticks. Assumes one
// register write per cycle and that prot_on/prot_from are quasi-static.
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 6,
    parameter int SECT_OFF_W = 9,
    parameter int T_BLANK    = 4,
    parameter int T_BYTE     = 9,
    parameter int T_BURST    = 4,
    parameter int T_SECT     = 4000,
    parameter int T_MASS     = 20000,
    parameter int T_ABORT    = 4,
    localparam int SECT_W    = ADDR_W - SECT_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prot_on,
    input  logic [SECT_W-1:0] prot_from,
    output logic              div_set,
    output logic              tick,
    output logic              busy,
    output logic              cmd_done,
    output logic              acc_err,
    output logic              prot_err,
    output logic              arr_prog,
    output logic              arr_erase,
    output logic              arr_mass,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);
    localparam int CNT_W = $clog2(T_MASS + 1);

    reg_sel_e          sel;
    seq_state_e        state;
    logic [DIV_W-1:0]  div_val;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic [7:0]        op_q;
    logic              err_any;
    logic              prot_hit;
    logic              start;
    logic              is_prog;
    logic [CNT_W-1:0]  dur;
    logic              tmr_running;
    logic              tmr_fin;
    logic              sect_prot;

    assign sel     = reg_sel_e'(wr_sel);
    assign err_any = acc_err || prot_err;
    assign busy    = (state == SQ_RUN);
    assign is_prog = (op_q == OP_BYTE) || (op_q == OP_BURST);

    // Protection verdict for the armed opcode and captured address.
    always_comb begin
        sect_prot = prot_on && (lat_addr[ADDR_W-1:SECT_OFF_W] >= prot_from);
        case (op_q)
            OP_MASS:                   prot_hit = prot_on;
            OP_SECT, OP_BYTE, OP_BURST: prot_hit = sect_prot;
            default:                   prot_hit = 1'b0;
        endcase
    end

    // Accepted launch: armed, flags clear, no protection violation.
    assign start = wr_en && (sel == SEL_STAT) && wr_data[ST_LAUNCH] && !err_any &&
                   (state == SQ_ARMED) && !prot_hit;

    // Tick count for the armed opcode.
    always_comb begin
        case (op_q)
            OP_BLANK: dur = CNT_W'(T_BLANK);
            OP_BYTE:  dur = CNT_W'(T_BYTE);
            OP_BURST: dur = CNT_W'(T_BURST);
            OP_SECT:  dur = CNT_W'(T_SECT);
            OP_MASS:  dur = CNT_W'(T_MASS);
            default:  dur = CNT_W'(T_ABORT);
        endcase
    end

    flash_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (div_set),
        .restart (start),
        .div     (div_val),
        .tick    (tick)
    );

    flash_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (dur),
        .tick     (tick),
        .running  (tmr_running),
        .fin      (tmr_fin)
    );

    // Sequencer: register decode, step ordering, flags and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            div_set  <= 1'b0;
            div_val  <= '0;
            acc_err  <= 1'b0;
            prot_err <= 1'b0;
            cmd_done <= 1'b1;
            lat_addr <= '0;
            lat_data <= '0;
            op_q     <= '0;
        end else begin
            if (busy && tmr_fin) begin
                state    <= SQ_IDLE;
                cmd_done <= 1'b1;
            end
            if (wr_en) begin
                case (sel)
                    SEL_DIV: begin
                        if (!div_set && !err_any) begin
                            div_val <= wr_data[DIV_W-1:0];
                            div_set <= 1'b1;
                        end
                    end
                    SEL_STAT: begin
                        if (wr_data[ST_AERR]) acc_err  <= 1'b0;
                        if (wr_data[ST_PERR]) prot_err <= 1'b0;
                        if (wr_data[ST_LAUNCH] && !err_any) begin
                            if (state == SQ_ARMED) begin
                                if (prot_hit) begin
                                    prot_err <= 1'b1;
                                    state    <= SQ_IDLE;
                                end else begin
                                    state    <= SQ_RUN;
                                    cmd_done <= 1'b0;
                                end
                            end else begin
                                acc_err <= 1'b1;
                                if (!busy) state <= SQ_IDLE;
                            end
                        end
                    end
                    SEL_ARR: begin
                        if (!err_any) begin
                            if (!div_set || state != SQ_IDLE) begin
                                acc_err <= 1'b1;
                                if (!busy) state <= SQ_IDLE;
                            end else begin
                                lat_addr <= wr_addr;
                                lat_data <= wr_data;
                                state    <= SQ_LATCHED;
                            end
                        end
                    end
                    default: begin
                        if (!err_any) begin
                            if (state == SQ_LATCHED && op_valid(wr_data)) begin
                                op_q  <= wr_data;
                                state <= SQ_ARMED;
                            end else begin
                                acc_err <= 1'b1;
                                if (!busy) state <= SQ_IDLE;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Array stub drive.
    assign arr_prog  = busy && is_prog;
    assign arr_erase = busy && ((op_q == OP_SECT) || (op_q == OP_MASS));
    assign arr_mass  = busy && (op_q == OP_MASS);
    assign arr_addr  = lat_addr;
    assign arr_data  = is_prog ? lat_data : '0;

    AST_BUSY_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tmr_running); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !busy); // R8
    AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(acc_err) && !$past(prot_err)); // R7
    AST_MASS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_mass) |-> !$past(prot_on)); // R9
    AST_DIV_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_set && $past(div_set)) |-> $stable(div_val)); // R2

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prot_on = 1'b0;
    logic [2:0]  prot_from = '0;
    logic        div_set, tick, busy, cmd_done, acc_err, prot_err;
    logic        arr_prog, arr_erase, arr_mass;
    logic [11:0] arr_addr;
    logic [7:0]  arr_data;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int run_len = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .prot_on(prot_on),
        .prot_from(prot_from), .div_set(div_set), .tick(tick), .busy(busy),
        .cmd_done(cmd_done), .acc_err(acc_err), .prot_err(prot_err),
        .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_mass(arr_mass),
        .arr_addr(arr_addr), .arr_data(arr_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: measure each busy window and compare with the scoreboard.
    always @(negedge clk) begin
        if (busy) begin
            run_len++;
        end else if (run_len > 0) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected operation", run_len, 0);
            end else begin
                chk("R8 busy duration", run_len, exp_q.pop_front());
            end
            run_len = 0;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: push expected duration, then issue the three-step sequence.
    task automatic run_cmd(input logic [11:0] a, input logic [7:0] d,
                           input logic [7:0] op, input int cyc);
        wr(2'd3, a, d);
        wr(2'd1, 12'h0, op);
        exp_q.push_back(cyc);
        wr(2'd2, 12'h0, 8'h80);
        wait_idle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 div_set", div_set, 0);
        chk("R1 acc_err", acc_err, 0);
        chk("R1 cmd_done", cmd_done, 1);
        chk("R1 arr_prog", arr_prog, 0);

        // R4 array write before divisor
        wr(2'd3, 12'h010, 8'h11);
        chk("R4 acc_err", acc_err, 1);
        // R7 divisor ignored while flag set
        wr(2'd0, 12'h0, 8'd3);
        chk("R7 div blocked", div_set, 0);
        wr(2'd2, 12'h0, 8'h10);
        chk("R7 clear", acc_err, 0);

        // R2 divisor accepted
        wr(2'd0, 12'h0, 8'd3);
        chk("R2 div_set", div_set, 1);

        // R3 tick spacing
        begin
            int gap = 0;
            while (!tick) @(negedge clk);
            @(negedge clk);
            gap = 1;
            while (!tick) begin @(negedge clk); gap++; end
            chk("R3 tick gap", gap, 4);
        end

        // R5 opcode without latch
        wr(2'd1, 12'h0, 8'h20);
        chk("R5 no latch", acc_err, 1);
        wr(2'd2, 12'h0, 8'h10);
        // R5 invalid code
        wr(2'd3, 12'h020, 8'h00);
        wr(2'd1, 12'h0, 8'h33);
        chk("R5 bad code", acc_err, 1);
        wr(2'd2, 12'h0, 8'h10);
        // R6 launch without opcode
        wr(2'd3, 12'h020, 8'h00);
        wr(2'd2, 12'h0, 8'h80);
        chk("R6 launch early", acc_err, 1);
        chk("R6 not busy", busy, 0);
        // R7 array write ignored while flag set: opcode then still lacks a latch
        wr(2'd3, 12'h020, 8'h00);
        wr(2'd2, 12'h0, 8'h10);
        wr(2'd1, 12'h0, 8'h20);
        chk("R7 latch ignored", acc_err, 1);
        wr(2'd2, 12'h0, 8'h10);

        // R10/R8 byte program with mid-run write (R11)
        wr(2'd3, 12'h2A5, 8'h5C);
        wr(2'd1, 12'h0, 8'h20);
        exp_q.push_back(9 * 4);
        wr(2'd2, 12'h0, 8'h80);
        chk("R10 arr_prog", arr_prog, 1);
        chk("R10 arr_addr", arr_addr, 12'h2A5);
        chk("R10 arr_data", arr_data, 8'h5C);
        chk("R8 cmd_done low", cmd_done, 0);
        wr(2'd1, 12'h0, 8'h40);
        chk("R11 acc_err", acc_err, 1);
        chk("R11 still busy", busy, 1);
        wait_idle();
        chk("R8 cmd_done high", cmd_done, 1);
        wr(2'd2, 12'h0, 8'h10);

        // R9 protection
        prot_on = 1'b1; prot_from = 3'd4;
        wr(2'd3, 12'h000, 8'h00);
        wr(2'd1, 12'h0, 8'h41);
        wr(2'd2, 12'h0, 8'h80);
        chk("R9 mass prot", prot_err, 1);
        chk("R9 mass no busy", busy, 0);
        wr(2'd2, 12'h0, 8'h20);
        chk("R7 prot clear", prot_err, 0);
        wr(2'd3, 12'h900, 8'h00);
        wr(2'd1, 12'h0, 8'h40);
        wr(2'd2, 12'h0, 8'h80);
        chk("R9 sector prot", prot_err, 1);
        wr(2'd2, 12'h0, 8'h20);

        // R10 sector erase in unprotected sector: data forced to 0
        wr(2'd3, 12'h3FF, 8'hEE);
        wr(2'd1, 12'h0, 8'h40);
        exp_q.push_back(4000 * 4);
        wr(2'd2, 12'h0, 8'h80);
        chk("R10 arr_erase", arr_erase, 1);
        chk("R10 erase data", arr_data, 0);
        chk("R10 not mass", arr_mass, 0);
        wait_idle();
        prot_on = 1'b0;

        // Second reset: divisor 1, rewrite ignored (R2)
        do_reset();
        wr(2'd0, 12'h0, 8'd1);
        wr(2'd0, 12'h0, 8'd5);
        run_cmd(12'h100, 8'hA0, 8'h20, 9 * 2);   // R2 R8 byte program
        run_cmd(12'h101, 8'hA1, 8'h25, 4 * 2);   // R8 burst
        run_cmd(12'h000, 8'h00, 8'h05, 4 * 2);   // R8 blank check
        run_cmd(12'h000, 8'h00, 8'h47, 4 * 2);   // R8 abort
        wr(2'd3, 12'h7F0, 8'h00);
        wr(2'd1, 12'h0, 8'h41);
        exp_q.push_back(20000 * 2);
        wr(2'd2, 12'h0, 8'h80);
        chk("R10 arr_mass", arr_mass, 1);
        wait_idle();
        chk("R8 scoreboard drained", exp_q.size(), 0);
        chk("R2 no error", acc_err, 0);
        finish_run();
    end
endmodule